// File: doc/BRIEF.md
# Rotating Register Loop Branch Controller

This block is the branch-side control for software-pipelined loops. It holds a 64-bit loop counter, a small epilogue counter and two rotation bases. One base is for the rotating general registers and the other is for the rotating predicate registers. When a pipelined loop-closing branch arrives, the block does four things:

- decides whether the branch is taken;
- updates the counters;
- rotates both bases;
- writes the value of the first rotating predicate.

Because of this, the stage predicates of a modulo-scheduled loop are produced automatically, and the loop runs without separate fill and drain code.

The block also serves a plain counted-loop branch. That branch only counts down, and it does not rotate the bases. Two combinational translators turn a virtual register number into a physical one using the current bases. The register storage and instruction fetch sit outside this block.

Software loads both counters through a write port before the loop starts.

Top module: `loop_rotation_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, both bases, the loop count and the epilogue count read 0.
- R2: When `cnt_wr_en` is high, the loop count and epilogue count take `cnt_wr_lc` and `cnt_wr_ec` at the next edge. Any branch request in that cycle is ignored: `br_taken` and `stage_pred_we` stay 0 and the bases stay unchanged.
- R3: A pipelined branch (`br_pipelined`=1) with a nonzero loop count is taken. It decrements the loop count, asserts `stage_pred_we` with `stage_pred_val`=1, and decrements both bases.
- R4: A pipelined branch with a zero loop count and a nonzero epilogue count is taken. It decrements the epilogue count, asserts `stage_pred_we` with `stage_pred_val`=0, and decrements both bases.
- R5: A pipelined branch with both counts zero falls through: `br_taken`=0 and `stage_pred_we`=0, and no counter or base changes.
- R6: A base decrement wraps around within its region. The general base goes from 0 to 95 and the predicate base goes from 0 to 47.
- R7: A counted branch (`br_pipelined`=0) is taken when the loop count is nonzero, and then decrements the count. It never rotates the bases and never asserts `stage_pred_we`. With a zero count it falls through and the count stays 0.
- R8: For a general register number v in 32..127, `gr_phys` = 32 + ((v − 32 + general base) mod 96).
- R9: For a predicate number v in 16..63, `pr_phys` = 16 + ((v − 16 + predicate base) mod 48).
- R10: Numbers below the rotating region (general below 32, predicate below 16) pass through unchanged.
- R11: When `br_valid` is low, the counters and bases keep their values.
- R12: The loop count decrements correctly across its full 64-bit width, with the borrow passing through bit 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_wr_en | input | 1 | Load both counters |
| cnt_wr_lc | input | 64 | Loop count value to load |
| cnt_wr_ec | input | 6 | Epilogue count value to load |
| br_valid | input | 1 | A loop branch is executing this cycle |
| br_pipelined | input | 1 | 1: rotating pipelined branch, 0: counted branch |
| br_taken | output | 1 | Branch outcome |
| stage_pred_we | output | 1 | Write the first rotating predicate |
| stage_pred_val | output | 1 | Value written to that predicate |
| lc_q | output | 64 | Current loop count |
| ec_q | output | 6 | Current epilogue count |
| gr_base_q | output | 7 | General register rotation base (0..95) |
| pr_base_q | output | 6 | Predicate rotation base (0..47) |
| gr_virt | input | 7 | Virtual general register number |
| gr_phys | output | 7 | Physical general register number |
| pr_virt | input | 6 | Virtual predicate number |
| pr_phys | output | 6 | Physical predicate number |

## Verification
The following are checked on every cycle:

- the counter step rules for each branch kind;
- the wrap of the general base at zero;
- the freezing of the bases on counted or exhausted branches;
- the loading of the counters by the write port;
- the pass-through of non-rotating register numbers.

Some properties only the bench's scenarios can show:

- a full fill, kernel and drain sequence with the exact predicate values;
- the mapped register numbers after several rotations, including at the top of each region;
- a 64-bit borrow;
- reset cleanly interrupting a loop partway through.

// File: rtl/loop_rotation_ctrl.sv
module loop_rotation_ctrl #(
  parameter int LC_W     = 64,
  parameter int EC_W     = 6,
  parameter int GR_FIRST = 32,
  parameter int GR_COUNT = 96,
  parameter int GR_IDX_W = 7,
  parameter int PR_FIRST = 16,
  parameter int PR_COUNT = 48,
  parameter int PR_IDX_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cnt_wr_en,
  input  logic [LC_W-1:0]       cnt_wr_lc,
  input  logic [EC_W-1:0]       cnt_wr_ec,
  input  logic                  br_valid,
  input  logic                  br_pipelined,
  output logic                  br_taken,
  output logic                  stage_pred_we,
  output logic                  stage_pred_val,
  output logic [LC_W-1:0]       lc_q,
  output logic [EC_W-1:0]       ec_q,
  output logic [$clog2(GR_COUNT)-1:0] gr_base_q,
  output logic [$clog2(PR_COUNT)-1:0] pr_base_q,
  input  logic [GR_IDX_W-1:0]   gr_virt,
  output logic [GR_IDX_W-1:0]   gr_phys,
  input  logic [PR_IDX_W-1:0]   pr_virt,
  output logic [PR_IDX_W-1:0]   pr_phys
);
  localparam int GB_W = $clog2(GR_COUNT);
  localparam int PB_W = $clog2(PR_COUNT);
  localparam logic [GB_W-1:0]     GB_TOP = GB_W'(GR_COUNT - 1);
  localparam logic [PB_W-1:0]     PB_TOP = PB_W'(PR_COUNT - 1);
  localparam logic [GB_W:0]       GR_N   = (GB_W+1)'(GR_COUNT);
  localparam logic [PB_W:0]       PR_N   = (PB_W+1)'(PR_COUNT);
  localparam logic [GR_IDX_W-1:0] GR_LO  = GR_IDX_W'(GR_FIRST);
  localparam logic [PR_IDX_W-1:0] PR_LO  = PR_IDX_W'(PR_FIRST);

  logic lc_nz, ec_nz, go, pipe_go, cnt_go, rotate;

  assign lc_nz   = |lc_q;
  assign ec_nz   = |ec_q;
  assign go      = br_valid && !cnt_wr_en;
  assign pipe_go = go && br_pipelined;
  assign cnt_go  = go && !br_pipelined;
  assign rotate  = pipe_go && (lc_nz || ec_nz);

  assign br_taken       = rotate || (cnt_go && lc_nz);
  assign stage_pred_we  = rotate;
  assign stage_pred_val = lc_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q      <= '0;
      ec_q      <= '0;
      gr_base_q <= '0;
      pr_base_q <= '0;
    end else if (cnt_wr_en) begin
      lc_q <= cnt_wr_lc;
      ec_q <= cnt_wr_ec;
    end else begin
      if (go && lc_nz)
        lc_q <= lc_q - LC_W'(1);
      if (pipe_go && !lc_nz && ec_nz)
        ec_q <= ec_q - EC_W'(1);
      if (rotate) begin
        gr_base_q <= (gr_base_q == '0) ? GB_TOP : gr_base_q - GB_W'(1);
        pr_base_q <= (pr_base_q == '0) ? PB_TOP : pr_base_q - PB_W'(1);
      end
    end
  end

  logic [GB_W:0] gr_sum, gr_wrap;
  logic [PB_W:0] pr_sum, pr_wrap;

  assign gr_sum  = (GB_W+1)'(gr_virt - GR_LO) + {1'b0, gr_base_q};
  assign gr_wrap = (gr_sum >= GR_N) ? gr_sum - GR_N : gr_sum;
  assign gr_phys = (gr_virt < GR_LO) ? gr_virt : GR_IDX_W'(gr_wrap) + GR_LO;

  assign pr_sum  = (PB_W+1)'(pr_virt - PR_LO) + {1'b0, pr_base_q};
  assign pr_wrap = (pr_sum >= PR_N) ? pr_sum - PR_N : pr_sum;
  assign pr_phys = (pr_virt < PR_LO) ? pr_virt : PR_IDX_W'(pr_wrap) + PR_LO;
endmodule

// File: rtl/loop_rotation_ctrl_chk.sv
module loop_rotation_ctrl_chk #(
  parameter int LC_W = 64, parameter int EC_W = 6,
  parameter int GR_FIRST = 32, parameter int GR_COUNT = 96, parameter int GR_IDX_W = 7,
  parameter int PR_FIRST = 16, parameter int PR_IDX_W = 6,
  parameter int GB_W = 7, parameter int PB_W = 6
) (
  input logic clk, input logic rst_n,
  input logic cnt_wr_en, input logic [LC_W-1:0] cnt_wr_lc, input logic [EC_W-1:0] cnt_wr_ec,
  input logic br_valid, input logic br_pipelined,
  input logic br_taken, input logic stage_pred_we, input logic stage_pred_val,
  input logic [LC_W-1:0] lc_q, input logic [EC_W-1:0] ec_q,
  input logic [GB_W-1:0] gr_base_q, input logic [PB_W-1:0] pr_base_q,
  input logic [GR_IDX_W-1:0] gr_virt, input logic [GR_IDX_W-1:0] gr_phys,
  input logic [PR_IDX_W-1:0] pr_virt, input logic [PR_IDX_W-1:0] pr_phys
);
  logic pipe_req;
  assign pipe_req = br_valid && !cnt_wr_en && br_pipelined;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> (lc_q == $past(cnt_wr_lc)) && (ec_q == $past(cnt_wr_ec)));

  assert_kernel_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_req && lc_q != '0) |=> (lc_q == $past(lc_q) - LC_W'(1)) && $stable(ec_q));

  assert_drain_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_req && lc_q == '0 && ec_q != '0) |=> (ec_q == $past(ec_q) - EC_W'(1)) && (lc_q == '0));

  assert_fall_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_req && lc_q == '0 && ec_q == '0) |=> $stable(gr_base_q) && $stable(pr_base_q) && $stable(ec_q));

  assert_base_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_pred_we && gr_base_q == '0) |=> (gr_base_q == GB_W'(GR_COUNT - 1)));

  assert_counted_no_rotate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_pipelined && !cnt_wr_en) |=> $stable(gr_base_q) && $stable(pr_base_q));

  assert_counted_no_pred_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_pipelined) |-> !stage_pred_we);

  assert_pass_through_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_virt < GR_IDX_W'(GR_FIRST)) |-> (gr_phys == gr_virt));

  assert_pred_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_virt < PR_IDX_W'(PR_FIRST)) |-> (pr_phys == pr_virt));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !cnt_wr_en) |=> $stable(lc_q) && $stable(ec_q) && $stable(gr_base_q));
endmodule

bind loop_rotation_ctrl loop_rotation_ctrl_chk #(
  .LC_W(LC_W), .EC_W(EC_W), .GR_FIRST(GR_FIRST), .GR_COUNT(GR_COUNT), .GR_IDX_W(GR_IDX_W),
  .PR_FIRST(PR_FIRST), .PR_IDX_W(PR_IDX_W), .GB_W(GB_W), .PB_W(PB_W)
) i_chk (.*);

// File: tb/test_loop_rotation_ctrl.sv
module test_loop_rotation_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_wr_en = 1'b0;
  logic [63:0] cnt_wr_lc = '0;
  logic [5:0] cnt_wr_ec = '0;
  logic br_valid = 1'b0, br_pipelined = 1'b0;
  logic br_taken, stage_pred_we, stage_pred_val;
  logic [63:0] lc_q;
  logic [5:0] ec_q;
  logic [6:0] gr_base_q;
  logic [5:0] pr_base_q;
  logic [6:0] gr_virt = '0, gr_phys;
  logic [5:0] pr_virt = '0, pr_phys;

  int n_chk = 0, n_err = 0, rot = 0;

  always #10 clk = ~clk;

  loop_rotation_ctrl i_loop_rotation_ctrl (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // {req[33:30], wr[29], lc[28:21], ec[20:17], valid[16], pipe[15],
  //  taken[14], we[13], val[12], exp_lc[11:4], exp_ec[3:0]}
  localparam int NV = 12;
  localparam logic [33:0] VEC [0:NV-1] = '{
    {4'd2,  1'b1, 8'd2, 4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2, 4'd2}, // R2 load, branch ignored
    {4'd3,  1'b0, 8'd0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd1, 4'd2}, // R3 fill
    {4'd3,  1'b0, 8'd0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd0, 4'd2}, // R3 last kernel
    {4'd4,  1'b0, 8'd0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 4'd1}, // R4 drain
    {4'd4,  1'b0, 8'd0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 4'd0}, // R4 drain last
    {4'd5,  1'b0, 8'd0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 4'd0}, // R5 fall through
    {4'd11, 1'b1, 8'd3, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3, 4'd1}, // R11 load only
    {4'd11, 1'b0, 8'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3, 4'd1}, // R11 idle
    {4'd7,  1'b0, 8'd0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2, 4'd1}, // R7 counted
    {4'd7,  1'b0, 8'd0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1, 4'd1}, // R7
    {4'd7,  1'b0, 8'd0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 4'd1}, // R7
    {4'd7,  1'b0, 8'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 4'd1}  // R7 exhausted
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 lc", lc_q, 0);
    chk("R1 ec", {58'd0, ec_q}, 0);
    chk("R1 gr base", {57'd0, gr_base_q}, 0);
    chk("R1 pr base", {58'd0, pr_base_q}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lc after release", lc_q, 0);
    gr_virt = 7'd50;
    #1 chk("R8 identity at base 0", {57'd0, gr_phys}, 50);

    for (int k = 0; k < NV; k++) begin
      logic [33:0] v;
      string tag;
      v = VEC[k];
      tag = $sformatf("R%0d vec%0d", v[33:30], k);
      @(negedge clk);
      cnt_wr_en = v[29];
      cnt_wr_lc = {56'd0, v[28:21]};
      cnt_wr_ec = {2'd0, v[20:17]};
      br_valid = v[16];
      br_pipelined = v[15];
      #2;
      chk({tag, " taken"}, {63'd0, br_taken}, {63'd0, v[14]});
      chk({tag, " pred we"}, {63'd0, stage_pred_we}, {63'd0, v[13]});
      if (v[13]) chk({tag, " pred val"}, {63'd0, stage_pred_val}, {63'd0, v[12]});
      if (v[16] && v[15] && v[14] && !v[29]) rot++;
      @(posedge clk);
      #2;
      chk({tag, " lc"}, lc_q, {56'd0, v[11:4]});
      chk({tag, " ec"}, {58'd0, ec_q}, {60'd0, v[3:0]});
      // R6: model base = -rot mod region size
      chk({tag, " R6 gr base"}, {57'd0, gr_base_q}, 64'((96 - rot % 96) % 96));
      chk({tag, " R6 pr base"}, {58'd0, pr_base_q}, 64'((48 - rot % 48) % 48));
    end
    @(negedge clk);
    cnt_wr_en = 1'b0; br_valid = 1'b0;

    // After 4 rotations: general base 92, predicate base 44
    gr_virt = 7'd32;  #1 chk("R8 gr 32", {57'd0, gr_phys}, 124);
    gr_virt = 7'd40;  #1 chk("R8 gr 40", {57'd0, gr_phys}, 36);
    gr_virt = 7'd127; #1 chk("R8 gr 127", {57'd0, gr_phys}, 123);
    pr_virt = 6'd16;  #1 chk("R9 pr 16", {58'd0, pr_phys}, 60);
    pr_virt = 6'd20;  #1 chk("R9 pr 20", {58'd0, pr_phys}, 16);
    pr_virt = 6'd63;  #1 chk("R9 pr 63", {58'd0, pr_phys}, 59);
    gr_virt = 7'd5;   #1 chk("R10 gr 5", {57'd0, gr_phys}, 5);
    pr_virt = 6'd3;   #1 chk("R10 pr 3", {58'd0, pr_phys}, 3);

    // R12: borrow across bit 32
    @(negedge clk);
    cnt_wr_en = 1'b1; cnt_wr_lc = 64'h1_0000_0000; cnt_wr_ec = 6'd0;
    @(negedge clk);
    cnt_wr_en = 1'b0; br_valid = 1'b1; br_pipelined = 1'b0;
    @(negedge clk);
    br_valid = 1'b0;
    chk("R12 lc borrow", lc_q, 64'h0000_0000_FFFF_FFFF);

    // R1: reset in mid loop
    cnt_wr_en = 1'b1; cnt_wr_lc = 64'd9; cnt_wr_ec = 6'd3;
    @(negedge clk);
    cnt_wr_en = 1'b0; br_valid = 1'b1; br_pipelined = 1'b1;
    @(negedge clk);
    br_valid = 1'b0;
    rst_n = 1'b0;
    #2;
    chk("R1 lc cleared", lc_q, 0);
    chk("R1 ec cleared", {58'd0, ec_q}, 0);
    chk("R1 gr base cleared", {57'd0, gr_base_q}, 0);
    chk("R1 pr base cleared", {58'd0, pr_base_q}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule